// File: doc/BRIEF.md
# Shortest-Burst Bus Arbiter

This block decides which of several requesters may drive a shared bus. Each requester raises a request line and declares how many beats its transfer will take. Whenever the bus is free, the arbiter picks the waiting requester with the smallest declared burst. Short, latency-sensitive transfers therefore go ahead of long bulk moves, which lowers the average wait across all requesters. Only one requester can hold the bus at a time.

A grant is never taken away during a transaction. The owner keeps it until it pulses the shared completion input. The bus then stays unowned for one cycle, and the next decision is made using the lengths presented in that cycle. Each requester has a wait counter. When the counter reaches a parameterised limit, that requester is moved ahead of every requester that has not yet reached the limit. This puts a bound on how long a long burst can be held back.

Top module: `sjf_bus_arbiter`

## Requirements
- R1: `grant_o` never has more than one bit set. `busy_o` is high exactly when one bit of `grant_o` is set.
- R2: While reset is asserted and after its release, `grant_o` is all zeros and `busy_o` is low until a request is seen.
- R3: When the bus is free and at least one request is high at a rising clock edge, that edge sets the grant bit (bit i = requester i) of the requester with the smallest burst length.
- R4: When the smallest length is shared by several requesters, the one with the lowest index wins.
- R5: The owner keeps its grant until `done_i` is sampled high. A shorter newcomer does not remove it, and neither does the owner dropping its own request.
- R6: The edge that samples `done_i` high while busy clears `grant_o`. The next edge issues the new grant if requests are pending.
- R7: Burst lengths are read only at the decision edge. Changing a pending length while the bus is owned leaves the current grant unchanged, and the next decision uses the value present at that edge.
- R8: A requester that has waited AGE_LIMIT or more cycles (request high, not granted) beats every requester that has not. Among such requesters, the shortest length wins, then the lowest index.
- R9: `done_i` has no effect while the bus is free.
- R10: A requester whose request line is low at the decision edge is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_REQ | Request lines, bit i for requester i |
| burst_len_i | input | NUM_REQ*LEN_W | Declared burst lengths, requester i in bits [i*LEN_W +: LEN_W] |
| done_i | input | 1 | Owner signals transaction complete |
| grant_o | output | NUM_REQ | One-hot grant to the bus owner |
| busy_o | output | 1 | Bus currently owned |

## Verification
Two functions can act in the same decision cycle. One is the shortest-length choice. The other is the aging override, which applies when a long requester's wait counter saturates while a much shorter request is still pending. The bench sets this up by keeping a short requester as owner for longer than the wait limit while a long one waits. It then releases the bus and checks that the long requester gets the grant. A second release made after a short hold, before saturation, must still go to the short requester.

// File: rtl/sjf_pkg.sv
package sjf_pkg;
   typedef enum logic {
      BUS_FREE  = 1'b0,
      BUS_OWNED = 1'b1
   } bus_state_e;
endpackage

// File: rtl/sjf_wait_counter.sv
module sjf_wait_counter #(
   parameter int LIMIT = 16,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic granted,
   output logic aged
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !req || granted) begin
         cnt_q <= '0;
      end else if (cnt_q != CW'(LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign aged = (cnt_q == CW'(LIMIT));

   // R8: a saturated waiter stays aged until it is served or withdraws
   assert_aged_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (aged && req && !granted) |=> aged);
endmodule

// File: rtl/sjf_min_select.sv
module sjf_min_select #(
   parameter int NUM_REQ = 4,
   parameter int LEN_W   = 8,
   localparam int KEY_W  = LEN_W + 1
) (
   input  logic [NUM_REQ-1:0]       req,
   input  logic [NUM_REQ-1:0]       aged,
   input  logic [NUM_REQ*LEN_W-1:0] lens,
   output logic [NUM_REQ-1:0]       win
);
   logic [KEY_W-1:0] keys [NUM_REQ];

   // aged requesters get a zero top bit and so sort ahead of the rest
   for (genvar g = 0; g < NUM_REQ; g++) begin : g_key
      assign keys[g] = {~aged[g], lens[g*LEN_W +: LEN_W]};
   end

   always_comb begin
      logic [KEY_W-1:0] best;
      logic             found;
      best  = '1;
      found = 1'b0;
      win   = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         // strict compare keeps the lower index on equal keys
         if (req[i] && (!found || keys[i] < best)) begin
            best  = keys[i];
            found = 1'b1;
            win   = '0;
            win[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sjf_grant_ctrl.sv
module sjf_grant_ctrl
   import sjf_pkg::*;
#(
   parameter int NUM_REQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               any_req,
   input  logic [NUM_REQ-1:0] win,
   input  logic               done_i,
   output logic [NUM_REQ-1:0] grant_q,
   output logic               busy
);
   bus_state_e st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= BUS_FREE;
         grant_q <= '0;
      end else begin
         case (st_q)
            BUS_FREE: begin
               if (any_req) begin
                  grant_q <= win;
                  st_q    <= BUS_OWNED;
               end
            end
            BUS_OWNED: begin
               if (done_i) begin
                  grant_q <= '0;
                  st_q    <= BUS_FREE;
               end
            end
            default: st_q <= BUS_FREE;
         endcase
      end
   end

   assign busy = (st_q == BUS_OWNED);

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q) && (busy == (grant_q != '0)));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done_i) |=> ($stable(grant_q) && busy));

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done_i) |=> (grant_q == '0));

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !any_req) |=> (grant_q == '0));
endmodule

// File: rtl/sjf_bus_arbiter.sv
module sjf_bus_arbiter #(
   parameter int NUM_REQ   = 4,
   parameter int LEN_W     = 8,
   parameter int AGE_LIMIT = 16,
   parameter bit USE_AGING = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_REQ-1:0]         req_i,
   input  logic [NUM_REQ*LEN_W-1:0]   burst_len_i,
   input  logic                       done_i,
   output logic [NUM_REQ-1:0]         grant_o,
   output logic                       busy_o
);
   if (NUM_REQ < 2 || LEN_W < 1 || AGE_LIMIT < 1) begin : g_param_err
      $error("sjf_bus_arbiter: illegal parameter set");
   end

   logic [NUM_REQ-1:0] aged;
   logic [NUM_REQ-1:0] win;

   if (USE_AGING) begin : g_aging
      for (genvar g = 0; g < NUM_REQ; g++) begin : g_cnt
         sjf_wait_counter #(.LIMIT(AGE_LIMIT)) i_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_i[g]),
            .granted (grant_o[g]),
            .aged    (aged[g])
         );
      end
   end else begin : g_no_aging
      assign aged = '0;
   end

   sjf_min_select #(.NUM_REQ(NUM_REQ), .LEN_W(LEN_W)) i_sel (
      .req  (req_i),
      .aged (aged),
      .lens (burst_len_i),
      .win  (win)
   );

   sjf_grant_ctrl #(.NUM_REQ(NUM_REQ)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_req (|req_i),
      .win     (win),
      .done_i  (done_i),
      .grant_q (grant_o),
      .busy    (busy_o)
   );

   assert_pick_requester_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && (req_i != '0)) |=> ((grant_o & $past(req_i)) != '0));

   assert_aged_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && ((req_i & aged) != '0)) |=> ((grant_o & $past(req_i & aged)) != '0));
endmodule

// File: tb/test_sjf_bus_arbiter.sv
module test_sjf_bus_arbiter;
   localparam int N  = 4;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_r = '0;
   logic [LW-1:0] len_r [N];
   logic [N*LW-1:0] len_flat;
   logic          done_r = 1'b0;
   logic [N-1:0]  grant;
   logic          busy;
   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   for (genvar g = 0; g < N; g++) begin : g_flat
      assign len_flat[g*LW +: LW] = len_r[g];
   end

   sjf_bus_arbiter #(.NUM_REQ(N), .LEN_W(LW), .AGE_LIMIT(6)) i_sjf_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .req_i(req_r), .burst_len_i(len_flat),
      .done_i(done_r), .grant_o(grant), .busy_o(busy)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // pulse done for one edge; grant must be clear afterwards
   task automatic release_bus(string tag);
      done_r = 1'b1;
      tick(1);
      done_r = 1'b0;
      chk({tag, " grant cleared"}, 32'(grant), 32'h0);
      chk({tag, " busy cleared"}, 32'(busy), 32'h0);
   endtask

   task automatic clean();
      req_r = '0;
      if (busy) begin
         done_r = 1'b1;
         tick(1);
         done_r = 1'b0;
      end
      tick(2);
   endtask

   task automatic t_reset();
      chk("R2 grant in reset", 32'(grant), 32'h0);
      chk("R2 busy in reset", 32'(busy), 32'h0);
      rst_n = 1'b1;
      tick(2);
      chk("R2 grant after reset", 32'(grant), 32'h0);
      chk("R1 busy low after reset", 32'(busy), 32'h0);
   endtask

   task automatic t_shortest();
      len_r[0] = 8'd40; len_r[1] = 8'd9; len_r[2] = 8'd3; len_r[3] = 8'd100;
      req_r = 4'b1111;
      tick(1);
      chk("R3 shortest of four", 32'(grant), 32'h4);
      chk("R1 busy with grant", 32'(busy), 32'h1);
      req_r[2] = 1'b0;
      release_bus("R6");
      tick(1);
      chk("R6 next grant after gap R3", 32'(grant), 32'h2);
      clean();
   endtask

   task automatic t_tie();
      len_r[0] = 8'd50; len_r[1] = 8'd7; len_r[2] = 8'd60; len_r[3] = 8'd7;
      req_r = 4'b1011;
      tick(1);
      chk("R4 equal lengths lower index", 32'(grant), 32'h2);
      clean();
   endtask

   task automatic t_nonpreempt();
      len_r[3] = 8'd90;
      req_r = 4'b1000;
      tick(1);
      chk("R5 sole requester granted", 32'(grant), 32'h8);
      len_r[0] = 8'd1;
      req_r[0] = 1'b1;
      tick(3);
      chk("R5 shorter newcomer no preempt", 32'(grant), 32'h8);
      req_r[3] = 1'b0;
      tick(2);
      chk("R5 owner drop keeps grant", 32'(grant), 32'h8);
      chk("R5 busy held", 32'(busy), 32'h1);
      release_bus("R6 after hold");
      tick(1);
      chk("R6 waiting requester next", 32'(grant), 32'h1);
      clean();
   endtask

   task automatic t_len_sample();
      len_r[0] = 8'd30; len_r[1] = 8'd10; len_r[2] = 8'd20;
      req_r = 4'b0111;
      tick(1);
      chk("R7 initial pick", 32'(grant), 32'h2);
      len_r[2] = 8'd2;
      len_r[1] = 8'd200;
      tick(2);
      chk("R7 length change while owned ignored", 32'(grant), 32'h2);
      req_r[1] = 1'b0;
      release_bus("R7");
      tick(1);
      chk("R7 new length used at decision", 32'(grant), 32'h4);
      clean();
   endtask

   task automatic t_dropped();
      len_r[1] = 8'd50; len_r[2] = 8'd1; len_r[3] = 8'd80;
      req_r = 4'b0010;
      tick(1);
      chk("R10 owner granted", 32'(grant), 32'h2);
      req_r = 4'b1100;
      tick(1);
      req_r[2] = 1'b0;
      release_bus("R10");
      tick(1);
      chk("R10 withdrawn short request skipped", 32'(grant), 32'h8);
      req_r = '0;
      release_bus("R10 last");
      tick(2);
      chk("R10 no request no grant", 32'(grant), 32'h0);
      clean();
   endtask

   task automatic t_done_idle();
      done_r = 1'b1;
      tick(3);
      done_r = 1'b0;
      chk("R9 done while free grant", 32'(grant), 32'h0);
      chk("R9 done while free busy", 32'(busy), 32'h0);
      len_r[1] = 8'd4;
      req_r = 4'b0010;
      tick(1);
      chk("R9 normal grant afterwards", 32'(grant), 32'h2);
      clean();
   endtask

   task automatic t_aging();
      len_r[0] = 8'd1; len_r[3] = 8'd200;
      req_r = 4'b1001;
      tick(1);
      chk("R3 short beats long", 32'(grant), 32'h1);
      release_bus("R8 short hold");
      tick(1);
      chk("R8 not yet aged short wins", 32'(grant), 32'h1);
      tick(5);
      release_bus("R8 long hold");
      tick(1);
      chk("R8 aged long requester wins", 32'(grant), 32'h8);
      clean();
   endtask

   initial begin
      for (int i = 0; i < N; i++) len_r[i] = '0;
      tick(3);
      t_reset();
      t_shortest();
      t_tie();
      t_nonpreempt();
      t_len_sample();
      t_dropped();
      t_done_idle();
      t_aging();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule